// File: doc/BRIEF.md
# Compare and auto-reload system timer

This block is a memory-mapped timer that follows a free-running 64-bit count supplied on an input port. It drives one level-sensitive interrupt. Software reaches it through a 32-bit word register bus with separate read and write strobes. Each access takes one cycle, and read data comes back from a register.

In compare mode, the timer fires once the count has reached an absolute 64-bit compare value. Software can also program that compare value as a signed 32-bit offset from the present count, and read it back the same way. In auto-increment mode, the timer sets its own target at the present count plus a reload amount. Each time the count reaches that target, the timer sets a sticky flag and moves the target forward again. While this mode is on, the sticky flag alone drives the interrupt and the compare value is ignored.

Top module: `cmp_reload_timer`

## Requirements
- R1: The compare value is accessed as two 32-bit words, low half at 0x20 and high half at 0x24. The condition is met when count >= compare value, taken as unsigned 64-bit numbers.
- R2: Reading 0x28 returns bits [31:0] of (compare value - count). Writing 0x28 sets the compare value to count plus the written word sign-extended to 64 bits.
- R3: The control word at 0x2C has these bits: bit 0 enables the timer, bit 1 masks the interrupt, and bit 2 is a read-only status that shows the present condition. Writes to bit 2 and bits [31:3] are ignored.
- R4: The condition is false while the enable bit is 0. irq_o goes high one cycle after a cycle in which the condition is true and the mask bit is 0. Otherwise irq_o is low.
- R5: The auto-increment control word at 0x4C has a read/write enable in bit 0 and a sticky flag in bit 1. Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 leaves it unchanged.
- R6: Auto-increment becomes active when the 0x4C enable goes from 0 to 1 while the control enable is 1, or when the control enable goes from 0 to 1 while the 0x4C enable is 1. At that point the target is loaded with count plus the 32-bit reload word held at 0x48. The target reads back at 0x40 (low half) and 0x44 (high half).
- R7: While both enables are 1 and count >= target, the sticky flag is set and the target is reloaded with count plus reload. In this mode the condition equals the sticky flag, so the compare value raises no interrupt.
- R8: The following are read-only and ignore writes: the count at 0x00 (low half) and 0x04 (high half), the target words, and the configuration word at 0x50, which reads 1.
- R9: Offset 0x10 is plain 32-bit read/write storage. Reset clears that storage, the control word, the compare value, the target, the auto-increment control word and the reload word.
- R10: Reads from unmapped offsets return 0, and writes to them change nothing. rdata is 0 in any cycle after one with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Free-running system count |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong enable, mask or sticky-flag bit appears on irq_o one cycle later, because the interrupt is recomputed from that state every cycle. A bad compare value or target stays hidden until the count crosses it. For that reason the bench reads both back through their own offsets and through the signed relative view, and it compares irq_o and rdata against a model on every cycle. A mistake in sign extension shows up at once in the high half of the compare value. A fault that lets the compare path leak into auto-increment mode raises irq_o within one cycle of the mode being armed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam logic [DATA_W-1:0] CFG_WORD = 32'd1;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FREQ    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_REL     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_CTL     = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_TGT_LO  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_TGT_HI  = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_AUTOCTL = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h050;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] freq_q,
  output logic              en_q,
  output logic              imask_q,
  output logic [CNT_W-1:0]  cval_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              ai_en_q,
  output logic              clr_wr0,
  output logic              arm
);
  logic [DATA_W-1:0] freq_d, reload_d;
  logic              en_d, imask_d, ai_en_d;
  logic [CNT_W-1:0]  cval_d, rel_sext;
  logic              wr_freq, wr_clo, wr_chi, wr_rel, wr_ctl, wr_rld, wr_actl;

  assign wr_freq = wr_en && (addr == OFS_FREQ);
  assign wr_clo  = wr_en && (addr == OFS_CMP_LO);
  assign wr_chi  = wr_en && (addr == OFS_CMP_HI);
  assign wr_rel  = wr_en && (addr == OFS_REL);
  assign wr_ctl  = wr_en && (addr == OFS_CTL);
  assign wr_rld  = wr_en && (addr == OFS_RELOAD);
  assign wr_actl = wr_en && (addr == OFS_AUTOCTL);

  assign rel_sext = {{DATA_W{wdata[DATA_W-1]}}, wdata};

  // Activation happens only on a 0 -> 1 edge of either enable while the other is set
  assign arm     = (wr_ctl && wdata[0] && !en_q && ai_en_q) ||
                   (wr_actl && wdata[0] && !ai_en_q && en_q);
  assign clr_wr0 = wr_actl && !wdata[1];

  always_comb begin
    freq_d   = freq_q;
    en_d     = en_q;
    imask_d  = imask_q;
    cval_d   = cval_q;
    reload_d = reload_q;
    ai_en_d  = ai_en_q;
    if (wr_freq) freq_d = wdata;
    if (wr_clo)  cval_d = {cval_q[CNT_W-1:DATA_W], wdata};
    if (wr_chi)  cval_d = {wdata, cval_q[DATA_W-1:0]};
    if (wr_rel)  cval_d = count_i + rel_sext;
    if (wr_ctl) begin
      en_d    = wdata[0];
      imask_d = wdata[1];
    end
    if (wr_rld)  reload_d = wdata;
    if (wr_actl) ai_en_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q   <= '0;
      en_q     <= 1'b0;
      imask_q  <= 1'b0;
      cval_q   <= '0;
      reload_q <= '0;
      ai_en_q  <= 1'b0;
    end else if (wr_en) begin
      freq_q   <= freq_d;
      en_q     <= en_d;
      imask_q  <= imask_d;
      cval_q   <= cval_d;
      reload_q <= reload_d;
      ai_en_q  <= ai_en_d;
    end
  end
endmodule

// File: rtl/tmr_autoinc.sv
module tmr_autoinc
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              arm,
  input  logic              clr_wr0,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] reload,
  output logic [CNT_W-1:0]  tgt_q,
  output logic              clr_q
);
  logic [CNT_W-1:0] next_tgt, tgt_d;
  logic             hit, clr_d, tgt_ce;

  assign next_tgt = count_i + {{DATA_W{1'b0}}, reload};
  assign hit      = active && (count_i >= tgt_q);
  assign tgt_ce   = arm || hit;

  always_comb begin
    tgt_d = next_tgt;
    clr_d = clr_q;
    if (hit)          clr_d = 1'b1;   // a fresh expiry wins over a clearing write
    else if (clr_wr0) clr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      if (tgt_ce) tgt_q <= tgt_d;
      clr_q <= clr_d;
    end
  end
endmodule

// File: rtl/tmr_cond.sv
module tmr_cond
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             imask,
  input  logic             ai_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cval,
  output logic             status,
  output logic             irq_q
);
  logic cmp_met, irq_d;

  assign cmp_met = (count_i >= cval);
  assign status  = en && (ai_en ? clr : cmp_met);
  assign irq_d   = status && !imask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] freq_q, reload_q, rd_mux, rdata_d;
  logic              en_q, imask_q, ai_en_q, clr_wr0, arm, clr_q, status;
  logic [CNT_W-1:0]  cval_q, tgt_q, rel_diff;

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count_i(count_i), .freq_q(freq_q), .en_q(en_q), .imask_q(imask_q),
    .cval_q(cval_q), .reload_q(reload_q), .ai_en_q(ai_en_q),
    .clr_wr0(clr_wr0), .arm(arm)
  );

  tmr_autoinc u_auto (
    .clk(clk), .rst_n(rst_n), .active(en_q && ai_en_q), .arm(arm),
    .clr_wr0(clr_wr0), .count_i(count_i), .reload(reload_q),
    .tgt_q(tgt_q), .clr_q(clr_q)
  );

  tmr_cond u_cond (
    .clk(clk), .rst_n(rst_n), .en(en_q), .imask(imask_q), .ai_en(ai_en_q),
    .clr(clr_q), .count_i(count_i), .cval(cval_q), .status(status),
    .irq_q(irq_o)
  );

  assign rel_diff = cval_q - count_i;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CNT_LO:  rd_mux = count_i[DATA_W-1:0];
      OFS_CNT_HI:  rd_mux = count_i[CNT_W-1:DATA_W];
      OFS_FREQ:    rd_mux = freq_q;
      OFS_CMP_LO:  rd_mux = cval_q[DATA_W-1:0];
      OFS_CMP_HI:  rd_mux = cval_q[CNT_W-1:DATA_W];
      OFS_REL:     rd_mux = rel_diff[DATA_W-1:0];
      OFS_CTL:     rd_mux = {{(DATA_W-3){1'b0}}, status, imask_q, en_q};
      OFS_TGT_LO:  rd_mux = tgt_q[DATA_W-1:0];
      OFS_TGT_HI:  rd_mux = tgt_q[CNT_W-1:DATA_W];
      OFS_RELOAD:  rd_mux = reload_q;
      OFS_AUTOCTL: rd_mux = {{(DATA_W-2){1'b0}}, clr_q, ai_en_q};
      OFS_CFG:     rd_mux = CFG_WORD;
      default:     rd_mux = '0;
    endcase
  end

  assign rdata_d = rd_en ? rd_mux : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic              en_q,
  input logic              imask_q,
  input logic              ai_en_q,
  input logic              clr_q
);
  p_mask_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imask_q |=> !irq_o);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o);

  p_auto_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ai_en_q && !clr_q) |=> !irq_o);

  p_auto_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ai_en_q && clr_q && !imask_q) |=> irq_o);

  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_q) |-> $past(en_q && ai_en_q));

  p_cfg_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_CFG) |=> (rdata == CFG_WORD));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

bind cmp_reload_timer tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_o(irq_o), .en_q(en_q), .imask_q(imask_q), .ai_en_q(ai_en_q),
  .clr_q(clr_q)
);

// File: tb/tb_cmp_reload_timer.sv
module tb_cmp_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cmp_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  // count source, advanced away from the sampling edge
  always @(negedge clk) begin
    if (!rst_n) cnt <= 64'h0000_0001_FFFF_FF00;
    else        cnt <= cnt + 64'd1;
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h000, 12'h004, 12'h050: return "R8";
      12'h010:                   return "R9";
      12'h020, 12'h024:          return "R1";
      12'h028:                   return "R2";
      12'h02C:                   return "R3";
      12'h040, 12'h044, 12'h048: return "R6";
      12'h04C:                   return "R5";
      default:                   return "R10";
    endcase
  endfunction

  // behavioural reference model
  logic [63:0] m_cval, m_tgt, m_sum;
  logic [31:0] m_freq, m_reload, m_rd;
  logic        m_en, m_mask, m_ai, m_clr, m_irq, m_st, m_hit, m_arm;
  string       m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cval = '0; m_tgt = '0; m_freq = '0; m_reload = '0; m_rd = '0;
      m_en = 0; m_mask = 0; m_ai = 0; m_clr = 0; m_irq = 0; m_tag = "R9";
    end else begin
      m_st  = m_en && (m_ai ? m_clr : (cnt >= m_cval));
      m_irq = m_st && !m_mask;
      m_tag = rd_en ? req_of(addr) : "R10";
      m_rd  = 32'd0;
      if (rd_en) begin
        case (addr)
          12'h000: m_rd = cnt[31:0];
          12'h004: m_rd = cnt[63:32];
          12'h010: m_rd = m_freq;
          12'h020: m_rd = m_cval[31:0];
          12'h024: m_rd = m_cval[63:32];
          12'h028: m_rd = 32'(m_cval - cnt);
          12'h02C: m_rd = {29'd0, m_st, m_mask, m_en};
          12'h040: m_rd = m_tgt[31:0];
          12'h044: m_rd = m_tgt[63:32];
          12'h048: m_rd = m_reload;
          12'h04C: m_rd = {30'd0, m_clr, m_ai};
          12'h050: m_rd = 32'd1;
          default: m_rd = 32'd0;
        endcase
      end
      m_hit = m_en && m_ai && (cnt >= m_tgt);
      m_sum = cnt + {32'd0, m_reload};
      m_arm = 0;
      if (m_hit) begin m_clr = 1; m_tgt = m_sum; end
      if (wr_en) begin
        case (addr)
          12'h010: m_freq = wdata;
          12'h020: m_cval[31:0] = wdata;
          12'h024: m_cval[63:32] = wdata;
          12'h028: m_cval = cnt + {{32{wdata[31]}}, wdata};
          12'h02C: begin
            if (wdata[0] && !m_en && m_ai) m_arm = 1;
            m_en = wdata[0]; m_mask = wdata[1];
          end
          12'h048: m_reload = wdata;
          12'h04C: begin
            if (wdata[0] && !m_ai && m_en) m_arm = 1;
            m_ai = wdata[0];
            if (!wdata[1] && !m_hit) m_clr = 0;
          end
          default: ;
        endcase
      end
      if (m_arm) m_tgt = m_sum;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({m_tag, " rdata"}, {32'd0, rdata}, {32'd0, m_rd});
      chk(m_ai ? "R7 irq" : "R4 irq", {63'd0, irq_o}, {63'd0, m_irq});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(tag, {32'd0, rdata}, {32'd0, exp});
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 50000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R9 irq after reset", {63'd0, irq_o}, 64'd0);
    rd_chk(12'h02C, 32'd0, "R9 ctl reset");
    rd_chk(12'h010, 32'd0, "R9 freq reset");
    rd_chk(12'h024, 32'd0, "R9 cmp reset");
    wr(12'h010, 32'hCAFE_1234);
    rd_chk(12'h010, 32'hCAFE_1234, "R9 freq rw");
    rd_chk(12'h050, 32'd1, "R8 cfg");
    wr(12'h050, 32'h0000_00F0);
    wr(12'h004, 32'h5555_5555);
    rd_chk(12'h050, 32'd1, "R8 cfg after write");
    rd_chk(12'h004, 32'd1, "R8 count high");
    wr(12'h100, 32'h1111_1111);
    rd_chk(12'h100, 32'd0, "R10 unmapped read");
    rd_chk(12'h010, 32'hCAFE_1234, "R10 unmapped write no effect");
    // R1: 0x0_FFFFFFFF is below the count, 0x2_FFFFFFFF above it
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h02C, 32'h1);
    idle(1);
    chk("R1 irq on count >= compare", {63'd0, irq_o}, 64'd1);
    wr(12'h024, 32'h2);
    idle(1);
    chk("R1 irq off when compare above", {63'd0, irq_o}, 64'd0);
    rd_chk(12'h024, 32'h2, "R1 compare high");
    // R3: stray bits ignored, status read-only
    wr(12'h02C, 32'hFFFF_FFFB);
    rd_chk(12'h02C, 32'h3, "R3 ctl readback");
    wr(12'h024, 32'h0);
    rd_chk(12'h02C, 32'h7, "R3 status set");
    chk("R4 masked irq", {63'd0, irq_o}, 64'd0);
    wr(12'h02C, 32'h1);
    idle(1);
    chk("R4 unmasked irq", {63'd0, irq_o}, 64'd1);
    wr(12'h02C, 32'h0);
    idle(1);
    chk("R4 disabled irq", {63'd0, irq_o}, 64'd0);
    rd_chk(12'h02C, 32'h0, "R4 status false when disabled");
    // R2: negative relative write
    wr(12'h02C, 32'h1);
    wr(12'h024, 32'h7);
    wr(12'h028, 32'hFFFF_FFF6);
    idle(1);
    chk("R2 negative relative fires", {63'd0, irq_o}, 64'd1);
    rd_chk(12'h024, 32'h1, "R2 sign extension high half");
    rd(12'h028);
    wr(12'h028, 32'd100);
    idle(1);
    chk("R2 positive relative quiet", {63'd0, irq_o}, 64'd0);
    rd(12'h028);
    // R6/R7: auto-increment with the compare path already satisfied
    wr(12'h024, 32'h0);
    wr(12'h048, 32'd30);
    rd_chk(12'h048, 32'd30, "R6 reload rw");
    idle(1);
    chk("R4 compare path active", {63'd0, irq_o}, 64'd1);
    wr(12'h04C, 32'h1);
    idle(1);
    chk("R7 compare silenced in auto mode", {63'd0, irq_o}, 64'd0);
    rd_chk(12'h04C, 32'h1, "R5 enable readback");
    rd(12'h040);
    rd(12'h044);
    wr(12'h040, 32'h0);
    rd(12'h040);
    for (int i = 0; i < 60 && !irq_o; i++) @(negedge clk);
    chk("R7 auto expiry raises irq", {63'd0, irq_o}, 64'd1);
    rd_chk(12'h04C, 32'h3, "R7 flag set");
    wr(12'h04C, 32'h3);
    rd_chk(12'h04C, 32'h3, "R5 write one keeps flag");
    wr(12'h04C, 32'h1);
    rd_chk(12'h04C, 32'h1, "R5 write zero clears flag");
    chk("R7 irq follows cleared flag", {63'd0, irq_o}, 64'd0);
    rd(12'h040);
    // R6: re-arm via control enable edge
    wr(12'h02C, 32'h0);
    wr(12'h048, 32'd5);
    wr(12'h02C, 32'h1);
    rd(12'h040);
    rd(12'h044);
    idle(12);
    rd_chk(12'h04C, 32'h3, "R6 rearm with short reload expires");
    wr(12'h04C, 32'h0);
    idle(2);
    wr(12'h02C, 32'h0);
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule